// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Port

This block is a configuration path for transceiver tuning bits that writes one bit at a time. A single 32-bit control word holds a bit address, one data bit and one write strobe for each of up to four PHY instances. The PHY-side bank for the instance chosen by a parameter watches that word. When its own strobe bit rises, it stores the data bit at the addressed position of a 256-bit tuning array. The bank also decodes a few named tuning fields from the array.

The control word can be loaded directly by a CPU bus write. It can also be driven by a built-in sequencer. The sequencer takes an instance number, a start address, a value and a length, and writes the value least significant bit first to consecutive addresses. Each bit takes four control-word phases of one clock each: set the address with the strobe low, set the data bit, raise the strobe, lower the strobe. A build parameter makes the sequencer zero the whole word before its first bit.

Top module: `phy_tune_port`

## Requirements
- R1: After reset the control word is zero, busy and done are low, and every bit of the tuning array reads 0.
- R2: A bus write taken while the sequencer is idle (busy and done low, no start) loads the full word, and the word shows it from the next cycle.
- R3: In the word, the bit address sits in [15:8], the data bit in bit 7, and the strobe of instance n in bit 2n.
- R4: When this instance's strobe goes from 0 to 1 in the word, the data bit is stored at the addressed array position. It reads back on rd_bit one cycle after the word first shows the strobe high.
- R5: A strobe held high while the data bit changes does not write the array. A strobe rising for another instance does not write the array either.
- R6: The sequencer writes a value of length L LSB first to addresses A to A+L-1, with the address wrapping modulo 256. Done pulses for one cycle exactly 4L cycles after the start edge, plus one cycle when the clear-first option is set.
- R7: A length of 0 gives done on the cycle after start and leaves the word unchanged. A length above 8 is treated as 8.
- R8: With the clear-first option, once a sequence ends the word holds only the last address in [15:8] and the last data bit in bit 7. Every other bit is 0.
- R9: Bus writes are ignored while busy or done is high.
- R10: The decoded fields are:
  - term_trim is array bit 0x0C for instance 0 and 0 for other instances.
  - amp_slew is bits 0x24..0x20, with the LSB at 0x20.
  - disc_thresh is bits 0x2B..0x2A.
  - squelch_en is high when bits 0x3D..0x3C are both 0.
- R11: A sequence aimed at another instance toggles that instance's strobe bit and leaves this array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | CPU write enable for the control word |
| bus_wdata | input | 32 | CPU write data |
| ctl_word | output | 32 | Current control word |
| seq_start | input | 1 | Start a sequenced write (sampled while idle) |
| seq_inst | input | 2 | Target instance of the sequence |
| seq_addr | input | 8 | First bit address |
| seq_value | input | 8 | Value to write, LSB first |
| seq_len | input | 4 | Number of bits (0 to 8, larger clamps to 8) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | 8 | Array readback address |
| rd_bit | output | 1 | Array bit at rd_addr |
| term_trim | output | 1 | Termination trim field |
| amp_slew | output | 5 | Amplitude/slew field |
| disc_thresh | output | 2 | Disconnect threshold field |
| squelch_en | output | 1 | Squelch detection enabled |

## Verification
A bus write appears in the word one cycle after its edge. The array bit follows one cycle later, so the bench checks the readback both before and after that edge. Done is due exactly 4L+1 cycles after the start edge, given the clear-first option set in the bench, and 0 cycles for a zero length. The bench counts edges until done is seen at a falling edge and compares the count with that figure. All array and field checks are made at falling edges once done is seen, against a bench-side model of the 256 bits.

// File: rtl/phy_tune_port.sv
module phy_tune_port #(
  parameter int INST        = 0,
  parameter bit CLEAR_FIRST = 1'b0,
  parameter int MAXLEN      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       ctl_word,
  input  logic              seq_start,
  input  logic [1:0]        seq_inst,
  input  logic [7:0]        seq_addr,
  input  logic [MAXLEN-1:0] seq_value,
  input  logic [$clog2(MAXLEN+1)-1:0] seq_len,
  output logic              busy,
  output logic              done,
  input  logic [7:0]        rd_addr,
  output logic              rd_bit,
  output logic              term_trim,
  output logic [4:0]        amp_slew,
  output logic [1:0]        disc_thresh,
  output logic              squelch_en
);
  localparam int LEN_W = $clog2(MAXLEN + 1);
  localparam int IDX_W = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
  localparam int SB    = 2 * INST;

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_ADDR, S_DATA, S_HI, S_LO, S_DONE} st_t;

  st_t                st;
  logic [31:0]        ctl_q;
  logic [1:0]         inst_q;
  logic [7:0]         base_q;
  logic [MAXLEN-1:0]  val_q;
  logic [LEN_W-1:0]   len_q, idx_q;
  logic [255:0]       tune_q;
  logic               sb_prev;

  wire [LEN_W-1:0] len_eff  = (seq_len > LEN_W'(MAXLEN)) ? LEN_W'(MAXLEN) : seq_len;
  wire [7:0]       cur_addr = base_q + 8'(idx_q);
  wire [31:0]      smask    = 32'd1 << {inst_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ctl_q  <= '0;
      inst_q <= '0;
      base_q <= '0;
      val_q  <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (seq_start) begin
            inst_q <= seq_inst;
            base_q <= seq_addr;
            val_q  <= seq_value;
            len_q  <= len_eff;
            idx_q  <= '0;
            if (len_eff == '0)    st <= S_DONE;
            else if (CLEAR_FIRST) st <= S_CLR;
            else                  st <= S_ADDR;
          end else if (bus_we) begin
            ctl_q <= bus_wdata;
          end
        S_CLR: begin
          ctl_q <= '0;
          st    <= S_ADDR;
        end
        S_ADDR: begin
          ctl_q <= (ctl_q & ~(smask | 32'h0000_FF00)) | {16'h0, cur_addr, 8'h00};
          st    <= S_DATA;
        end
        S_DATA: begin
          ctl_q[7] <= val_q[idx_q[IDX_W-1:0]];
          st       <= S_HI;
        end
        S_HI: begin
          ctl_q <= ctl_q | smask;
          st    <= S_LO;
        end
        S_LO: begin
          ctl_q <= ctl_q & ~smask;
          if (idx_q == len_q - LEN_W'(1)) st <= S_DONE;
          else begin
            idx_q <= idx_q + LEN_W'(1);
            st    <= S_ADDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_prev <= 1'b0;
      tune_q  <= '0;
    end else begin
      sb_prev <= ctl_q[SB];
      if (ctl_q[SB] && !sb_prev) tune_q[ctl_q[15:8]] <= ctl_q[7];
    end
  end

  assign ctl_word    = ctl_q;
  assign busy        = (st != S_IDLE) && (st != S_DONE);
  assign done        = (st == S_DONE);
  assign rd_bit      = tune_q[rd_addr];
  assign amp_slew    = tune_q[36:32];
  assign disc_thresh = tune_q[43:42];
  assign squelch_en  = (tune_q[61:60] == 2'b00);

  generate
    if (INST == 0) begin : g_trim
      assign term_trim = tune_q[12];
    end else begin : g_notrim
      assign term_trim = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/phy_tune_port_chk.sv
module phy_tune_port_chk #(
  parameter int INST = 0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] ctl_word,
  input logic        seq_start,
  input logic        busy,
  input logic        done,
  input logic [7:0]  rd_addr,
  input logic        rd_bit
);
  localparam int SB = 2 * INST;

  // R2
  bus_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !busy && !done && !seq_start) |=> (ctl_word == $past(bus_wdata)));

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_word[SB], 1) && !$past(ctl_word[SB], 2) && rd_addr == $past(ctl_word[15:8]))
      |-> (rd_bit == $past(ctl_word[7])));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && !($past(ctl_word[SB], 1) && !$past(ctl_word[SB], 2)))
      |-> $stable(rd_bit));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(seq_start));
endmodule

bind phy_tune_port phy_tune_port_chk #(.INST(INST)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .ctl_word(ctl_word), .seq_start(seq_start), .busy(busy), .done(done),
  .rd_addr(rd_addr), .rd_bit(rd_bit)
);

// File: tb/phy_tune_port_tb.sv
`timescale 1ns/1ps
module phy_tune_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] ctl_word;
  logic        seq_start = 1'b0;
  logic [1:0]  seq_inst = '0;
  logic [7:0]  seq_addr = '0;
  logic [7:0]  seq_value = '0;
  logic [3:0]  seq_len = '0;
  logic        busy, done;
  logic [7:0]  rd_addr = '0;
  logic        rd_bit, term_trim, squelch_en;
  logic [4:0]  amp_slew;
  logic [1:0]  disc_thresh;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [255:0] model = '0;

  always #2 clk = ~clk;

  phy_tune_port #(.INST(0), .CLEAR_FIRST(1'b1), .MAXLEN(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .ctl_word(ctl_word), .seq_start(seq_start), .seq_inst(seq_inst),
    .seq_addr(seq_addr), .seq_value(seq_value), .seq_len(seq_len),
    .busy(busy), .done(done), .rd_addr(rd_addr), .rd_bit(rd_bit),
    .term_trim(term_trim), .amp_slew(amp_slew), .disc_thresh(disc_thresh),
    .squelch_en(squelch_en)
  );

  // {inst, addr, value, len}
  localparam logic [21:0] VEC [8] = '{
    {2'd0, 8'h0C, 8'h01, 4'd1},
    {2'd0, 8'h20, 8'h14, 4'd5},
    {2'd0, 8'h2A, 8'h03, 4'd2},
    {2'd0, 8'h3C, 8'h02, 4'd2},
    {2'd1, 8'h40, 8'hFF, 4'd8},
    {2'd0, 8'hFF, 8'h03, 4'd2},
    {2'd0, 8'h80, 8'hA5, 4'd12},
    {2'd0, 8'h90, 8'hFF, 4'd0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] w);
    @(negedge clk); bus_we = 1'b1; bus_wdata = w;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic check_array(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); rd_addr = 8'(i); #1;
      if (rd_bit !== model[i]) bad++;
    end
    chk(bad, 0, tag);
  endtask

  task automatic run_vec(input logic [21:0] v, input bit junk);
    logic [1:0] inst = v[21:20];
    logic [7:0] addr = v[19:12];
    logic [7:0] val = v[11:4];
    int len = (v[3:0] > 4'd8) ? 8 : int'(v[3:0]);
    int n = 0;
    int exp_n = (len == 0) ? 0 : 4 * len + 1;
    logic [31:0] prev, exp_w;
    @(negedge clk);
    prev = ctl_word;
    seq_inst = inst; seq_addr = addr; seq_value = val; seq_len = v[3:0];
    seq_start = 1'b1; bus_we = junk; bus_wdata = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk);
    seq_start = 1'b0;
    while (!done && n < 300) begin
      @(posedge clk); @(negedge clk); n++;
    end
    bus_we = 1'b0;
    // R6 R7 done timing
    chk(n, exp_n, "R6/R7 done cycle");
    for (int i = 0; i < len; i++)
      if (inst == 2'd0) model[8'(addr + 8'(i))] = val[i];
    if (len == 0) exp_w = prev;
    else exp_w = {16'h0, 8'(addr + 8'(len - 1)), val[len - 1], 7'h0};
    // R8 R9 word after sequence (junk bus writes ignored)
    chk(ctl_word, exp_w, junk ? "R9 word with bus writes during busy" : "R8 word after sequence");
    // R6 R11 R7 array contents
    check_array(inst != 2'd0 ? "R11 other instance array" : "R6 array contents");
    // R10 decoded fields
    chk({27'b0, term_trim, amp_slew, disc_thresh, squelch_en},
        {27'b0, model[12], model[36:32], model[43:42], (model[61:60] == 2'b00)}, "R10 fields");
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctl_word, 32'h0, "R1 word");
    chk({busy, done}, 2'b00, "R1 busy/done");
    check_array("R1 array zero");
    chk({squelch_en, amp_slew}, {1'b1, 5'h0}, "R1 fields");

    // R2 R3: address 0x50, data 1, strobe low
    bus_write(32'h0000_5080);
    chk(ctl_word, 32'h0000_5080, "R2 bus load");
    rd_addr = 8'h50;
    @(negedge clk); bus_we = 1'b1; bus_wdata = 32'h0000_5081;
    @(negedge clk); bus_we = 1'b0; #1;
    // R4 strobe visible in word, bit not yet captured
    chk({ctl_word[0], rd_bit}, 2'b10, "R4 before capture");
    @(negedge clk); #1;
    chk(rd_bit, 1'b1, "R4 captured one cycle later");
    model[8'h50] = 1'b1;
    // R5 data drops while strobe held high
    bus_write(32'h0000_5001);
    @(negedge clk); #1;
    chk(rd_bit, 1'b1, "R5 held strobe");
    // R5 R3 instance 1 strobe bit 2 rises
    bus_write(32'h0000_5000);
    bus_write(32'h0000_5004);
    @(negedge clk); #1;
    chk(rd_bit, 1'b1, "R5 other strobe");
    // R3 same word on bit 0 clears it
    bus_write(32'h0000_5001);
    @(negedge clk); #1;
    chk(rd_bit, 1'b0, "R3 own strobe bit 0");
    model[8'h50] = 1'b0;

    for (int k = 0; k < 8; k++) run_vec(VEC[k], k == 2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule